// File: doc/BRIEF.md
# I2C Serial Memory Target Controller

This block is the bus-facing controller of a 4096-byte serial memory that answers as a target on a two-wire I2C bus. It oversamples the clock and data lines in the system clock domain, filters out short glitches, finds START and STOP conditions, and recognises its own 7-bit target address. The fixed upper four address bits are 1010 and the lower three come from strap pins. It answers by pulling the data line low through an open-drain enable.

A write transaction carries a two-byte memory address, high byte first. Any data bytes that follow are handed one at a time to an external page buffer. A clean STOP then tells that buffer to start its internal write cycle. While the buffer reports busy, the controller does not acknowledge its own address, so a master can poll until the write is done. Reads fetch bytes from a synchronous memory port with one cycle of latency. A read can start at the current internal address, at an address loaded just before a repeated START, or continue through memory for as long as the master acknowledges. A single internal address pointer serves both writes and reads.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the data-line enable is off and no fetch, data or commit strobe is active. Bus activity before the first START is ignored, so even the block's own address clocked in without a START gets no acknowledge.
- R2: A START is the filtered data line falling while the filtered clock line is high. A STOP is the data line rising while the clock line is high. A START at any point releases the data line and restarts address reception.
- R3: The first byte after a START acknowledges only when bits 7..4 equal 1010 and bits 3..1 equal strap_i[2:0]. Bit 0 selects the direction: 1 is a read and 0 is a write. Any other first byte is left unacknowledged, and the block then waits for the next START.
- R4: While busy_i is high, the block does not acknowledge its own address, and it keeps the data line released.
- R5: A write-mode address is followed by two address bytes, high first. Only the low 4 bits of the high byte and all of the low byte form the 12-bit pointer; the upper 4 bits are ignored.
- R6: Each write data byte is acknowledged and appears for one cycle on wr_valid_o, with the pointer on wr_addr_o. The pointer then advances with wrap inside a 32-byte page: bits 4..0 increment and roll over, and the upper bits stay fixed.
- R7: A STOP that follows at least one complete data byte, with no partial byte pending, pulses wr_commit_o for one cycle.
- R8: A START or STOP that arrives in the middle of a byte discards that partial byte. A STOP that cuts a byte does not commit, and the pointer keeps the value it had after the last complete byte.
- R9: The data-line enable changes only after a falling clock edge, or at a START or STOP. The acknowledge is driven through the whole ninth clock.
- R10: A read-mode address with no address bytes before it returns the byte at the internal pointer. The pointer advances by one after every byte sent.
- R11: Two address bytes in write mode, then a repeated START and a read-mode address, return data from the newly loaded address.
- R12: During a read, an acknowledge from the master causes the next byte to be sent, and the pointer wraps from 4095 to 0. A non-acknowledge releases the line and returns the block to idle.
- R13: A pulse on either bus line shorter than FILT_CYC system clocks (3 by default) has no effect on the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| strap_i | input | 3 | Strap bits that set the low target address bits |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mem_rd_en_o | output | 1 | One-cycle fetch strobe to the memory port |
| mem_addr_o | output | 12 | Fetch address |
| mem_rd_data_i | input | 8 | Fetched byte, valid the cycle after the strobe |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 12 | Memory address of that byte |
| wr_data_o | output | 8 | Received data byte |
| wr_commit_o | output | 1 | One-cycle pulse that starts the write cycle |
| busy_i | input | 1 | Write cycle in progress |

## Verification
The checker watches every cycle for the following conditions. The data-line enable moves only after a falling clock, a START or a STOP. A START always leaves the line released. An address decision drives the acknowledge if and only if the address matched and busy_i was low. Write strobes follow a falling clock and commits follow a STOP. Fetch strobes last exactly one cycle. Only the bench's transactions can show the byte values and pointer arithmetic: page wrap on writes, wrap at 4095 on reads, pointer carry-over between transactions, polling while busy, glitch rejection, and the effect of a byte cut short by START or STOP.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  // Target address match on the first byte after START.
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
    return b[7:1] == {DEV_PREFIX, strap};
  endfunction

  // Increment inside a page of 2**pg_bits bytes.
  function automatic logic [15:0] page_step(input logic [15:0] a, input int pg_bits);
    logic [15:0] mask;
    mask = 16'((32'd1 << pg_bits) - 32'd1);
    return (a & ~mask) | ((a + 16'd1) & mask);
  endfunction

  // Bit to drive after the n-th clock of a byte (MSB first).
  function automatic logic [2:0] tx_index(input logic [3:0] n);
    return 3'(3'd7 - n[2:0]);
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] != out_q) begin
        if (cnt_q == CW'(FILT_CYC - 1)) begin
          out_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign flt_o = out_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign ev_start = scl_p & scl_f & sda_p & ~sda_f;
  assign ev_stop  = scl_p & scl_f & ~sda_p & sda_f;
  assign ev_rise  = ~scl_p & scl_f;
  assign ev_fall  = scl_p & ~scl_f;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PAGE_BITS = 5,
  parameter int FILT_CYC  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  output logic              sda_oe_o,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  input  logic              busy_i
);
  localparam int HI_W = ADDR_W - 8;

  // Line conditioning, one filter per bus line.
  logic [1:0] raw_lines, flt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw_lines[g]),
      .flt_o (flt_lines[g])
    );
  end

  logic scl_f, sda_f;
  assign scl_f = flt_lines[0];
  assign sda_f = flt_lines[1];

  logic ev_start, ev_stop, ev_rise, ev_fall;
  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  // State.
  phase_e            ph_q;
  logic [3:0]        bit_q;
  logic              in_ack_q;
  logic [7:0]        sh_q;
  logic [7:0]        tx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [HI_W-1:0]   hi_q;
  logic              wrote_q;
  logic              oe_q;
  logic              rd_en_q;
  logic              rd_wait_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              wr_valid_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [7:0]        wr_data_q;
  logic              commit_q;

  // Named internal events.
  logic              rx_phase;
  logic              byte_done;
  logic              dev_decide;
  logic              addr_hit;
  logic              grant;
  logic              stop_clean;
  logic [ADDR_W-1:0] ptr_inc;
  logic [ADDR_W-1:0] ptr_pg;

  assign rx_phase   = (ph_q == PH_DEV) || (ph_q == PH_AHI) ||
                      (ph_q == PH_ALO) || (ph_q == PH_WR);
  assign byte_done  = ev_fall && !in_ack_q && (bit_q == 4'd8) && rx_phase;
  assign dev_decide = byte_done && (ph_q == PH_DEV);
  assign addr_hit   = dev_match(sh_q, strap_i);
  assign grant      = addr_hit && !busy_i;
  assign stop_clean = ev_stop && (ph_q == PH_WR) && wrote_q &&
                      (bit_q <= 4'd1) && !in_ack_q;
  assign ptr_inc    = ptr_q + ADDR_W'(1);
  assign ptr_pg     = ADDR_W'(page_step(16'(ptr_q), PAGE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      bit_q      <= '0;
      in_ack_q   <= 1'b0;
      sh_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      hi_q       <= '0;
      wrote_q    <= 1'b0;
      oe_q       <= 1'b0;
      rd_en_q    <= 1'b0;
      rd_wait_q  <= 1'b0;
      rd_addr_q  <= '0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      commit_q   <= 1'b0;
    end else begin
      rd_en_q    <= 1'b0;
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      rd_wait_q  <= rd_en_q;
      if (rd_wait_q) tx_q <= mem_rd_data_i;

      if (ev_start) begin
        ph_q     <= PH_DEV;
        bit_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
        wrote_q  <= 1'b0;
      end else if (ev_stop) begin
        commit_q <= stop_clean;
        ph_q     <= PH_IDLE;
        bit_q    <= '0;
        in_ack_q <= 1'b0;
        oe_q     <= 1'b0;
        wrote_q  <= 1'b0;
      end else if (ph_q != PH_IDLE) begin
        if (ev_rise) begin
          if (in_ack_q) begin
            bit_q <= '0;                       // ninth clock of our own ACK
          end else if (bit_q < 4'd8) begin
            sh_q  <= {sh_q[6:0], sda_f};
            bit_q <= bit_q + 4'd1;
          end else if (ph_q == PH_RD) begin    // master ACK/NoACK slot
            ptr_q <= ptr_inc;
            bit_q <= '0;
            if (!sda_f) begin
              rd_en_q   <= 1'b1;
              rd_addr_q <= ptr_inc;
            end else begin
              ph_q <= PH_IDLE;
            end
          end
        end else if (ev_fall) begin
          if (in_ack_q) begin
            in_ack_q <= 1'b0;
            oe_q     <= (ph_q == PH_RD) ? ~tx_q[7] : 1'b0;
          end else if (ph_q == PH_RD) begin
            oe_q <= (bit_q < 4'd8) ? ~tx_q[tx_index(bit_q)] : 1'b0;
          end else if (bit_q == 4'd8) begin
            case (ph_q)
              PH_DEV: begin
                if (grant) begin
                  oe_q     <= 1'b1;
                  in_ack_q <= 1'b1;
                  if (sh_q[0]) begin
                    ph_q      <= PH_RD;
                    rd_en_q   <= 1'b1;
                    rd_addr_q <= ptr_q;
                  end else begin
                    ph_q <= PH_AHI;
                  end
                end else begin
                  ph_q <= PH_IDLE;
                end
              end
              PH_AHI: begin
                hi_q     <= sh_q[HI_W-1:0];
                oe_q     <= 1'b1;
                in_ack_q <= 1'b1;
                ph_q     <= PH_ALO;
              end
              PH_ALO: begin
                ptr_q    <= {hi_q, sh_q};
                oe_q     <= 1'b1;
                in_ack_q <= 1'b1;
                ph_q     <= PH_WR;
              end
              PH_WR: begin
                oe_q       <= 1'b1;
                in_ack_q   <= 1'b1;
                wr_valid_q <= 1'b1;
                wr_addr_q  <= ptr_q;
                wr_data_q  <= sh_q;
                ptr_q      <= ptr_pg;
                wrote_q    <= 1'b1;
              end
              default: ph_q <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_rd_en_o = rd_en_q;
  assign mem_addr_o  = rd_addr_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = commit_q;
endmodule

// File: rtl/i2c_mem_target_sva.sv
module i2c_mem_target_sva (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_fall,
  input logic dev_decide,
  input logic addr_hit,
  input logic busy_i,
  input logic wr_valid,
  input logic wr_commit,
  input logic mem_rd_en
);
  a_r9_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(ev_fall || ev_start || ev_stop));

  a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_oe);

  a_r4_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && busy_i) |=> !sda_oe);

  a_r3_miss_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && !addr_hit) |=> !sda_oe);

  a_r3_hit_acks: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_decide && addr_hit && !busy_i) |=> sda_oe);

  a_r6_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(ev_fall));

  a_r7_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(ev_stop));

  a_r12_fetch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind i2c_mem_target i2c_mem_target_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .sda_oe     (oe_q),
  .ev_start   (ev_start),
  .ev_stop    (ev_stop),
  .ev_fall    (ev_fall),
  .dev_decide (dev_decide),
  .addr_hit   (addr_hit),
  .busy_i     (busy_i),
  .wr_valid   (wr_valid_q),
  .wr_commit  (commit_q),
  .mem_rd_en  (rd_en_q)
);

// File: tb/i2c_mem_target_test.sv
module i2c_mem_target_test;
  localparam int AW = 12;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int H = 20;
  localparam int Q = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, scl_m, sda_m;
  logic          sda_oe, mem_rd_en, wr_valid, wr_commit, busy;
  logic [AW-1:0] mem_addr, wr_addr;
  logic [7:0]    rdq, wr_data;
  wire           sda_line = sda_m & ~sda_oe;

  i2c_mem_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(STRAP),
    .sda_oe_o(sda_oe), .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr),
    .mem_rd_data_i(rdq), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit), .busy_i(busy)
  );

  logic [7:0] mem [0:4095];
  always @(posedge clk) if (mem_rd_en) rdq <= mem[mem_addr];

  int n_chk = 0, n_bad = 0, nv = 0, pend = 0, ncommit = 0, busy_cnt = 0;
  logic [AW-1:0] va [0:63];
  logic [7:0]    vd [0:63];
  logic          b8_oe;
  assign busy = (busy_cnt != 0);

  function automatic logic [7:0] init_val(input int a);
    return 8'(a * 37 + (a >> 8) + 17);
  endfunction

  // Page buffer and write-cycle model.
  always @(negedge clk) begin
    if (wr_valid && nv < 64) begin
      va[nv] = wr_addr;
      vd[nv] = wr_data;
      nv++;
    end
    if (wr_commit) begin
      for (int k = pend; k < nv; k++) mem[va[k]] = vd[k];
      pend = nv;
      ncommit++;
      busy_cnt = 3000;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i];
      wt(H / 2);
      if (glitch && i == 4) begin
        scl_m = 1'b1; wt(2); scl_m = 1'b0;
      end
      wt(H / 2);
      scl_m = 1'b1; wt(H / 2);
      if (i == 0) b8_oe = sda_oe;
      wt(H / 2);
      scl_m = 1'b0; wt(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    send_bits(b, 8, glitch);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H / 2);
    ack = !sda_line;
    wt(H / 2);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit ack_out, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(H);
      scl_m = 1'b1; wt(H / 2);
      b[i] = sda_line;
      wt(H / 2);
      scl_m = 1'b0; wt(Q);
    end
    sda_m = !ack_out; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic read_sel(input int a, input int n, input string tag);
    bit ack, all;
    logic [7:0] b;
    all = 1'b1;
    bus_start();
    send_byte(dev(0), 0, ack); all &= ack;
    send_byte(8'(a >> 8), 0, ack); all &= ack;
    send_byte(8'(a), 0, ack); all &= ack;
    bus_start();
    send_byte(dev(1), 0, ack); all &= ack;
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      chk(tag, {24'd0, b}, {24'd0, mem[(a + k) % 4096]});
    end
    bus_stop();
    chk({tag, " acks"}, {31'd0, all}, 32'd1);
  endtask

  task automatic read_cur(input int a, input string tag);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(dev(1), 0, ack);
    recv_byte(1'b0, b);
    bus_stop();
    chk(tag, {23'd0, ack, b}, {23'd0, 1'b1, mem[a % 4096]});
  endtask

  initial begin
    bit ack, all;
    int polls, vbase, cbase;
    logic [7:0] wd [0:3];
    for (int i = 0; i < 4096; i++) mem[i] = init_val(i);
    wd[0] = 8'hC1; wd[1] = 8'h3D; wd[2] = 8'h7E; wd[3] = 8'h90;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    wt(5);
    chk("R1 reset outputs", {28'd0, sda_oe, mem_rd_en, wr_valid, wr_commit}, 32'd0);
    rst_n = 1'b1; wt(10);

    // R1: own address clocked without START.
    scl_m = 1'b0; wt(H);
    send_byte(dev(0), 0, ack);
    chk("R1 no START no ack", {31'd0, ack}, 32'd0);
    bus_stop();

    // R3: address sweep over straps and direction.
    for (int s = 0; s < 8; s++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic [7:0] b;
        bus_start();
        send_byte({4'b1010, 3'(s), 1'(rw)}, 0, ack);
        if (ack && rw == 1) recv_byte(1'b0, b);
        bus_stop();
        chk("R3 strap match", {31'd0, ack}, {31'd0, 1'(3'(s) == STRAP)});
      end
    end
    for (int p = 0; p < 3; p++) begin
      logic [7:0] bad [0:2];
      bad[0] = 8'hBA; bad[1] = 8'h2A; bad[2] = 8'hEA;
      bus_start();
      send_byte(bad[p], 0, ack);
      bus_stop();
      chk("R3 prefix mismatch", {31'd0, ack}, 32'd0);
    end

    // R13: short clock glitch inside the address byte.
    bus_start();
    send_byte(dev(0), 1, ack);
    bus_stop();
    chk("R13 glitch filtered", {31'd0, ack}, 32'd1);
    chk("R9 no ack before 8th fall", {31'd0, b8_oe}, 32'd0);

    // R5/R6/R7: page write with ignored upper address bits and page wrap.
    all = 1'b1;
    bus_start();
    send_byte(dev(0), 0, ack); all &= ack;
    send_byte(8'hF0, 0, ack); all &= ack;
    send_byte(8'h3E, 0, ack); all &= ack;
    for (int k = 0; k < 4; k++) begin
      send_byte(wd[k], 0, ack); all &= ack;
    end
    bus_stop();
    chk("R6 data acks", {31'd0, all}, 32'd1);
    chk("R6 strobe count", nv, 4);
    for (int k = 0; k < 4; k++) begin
      logic [AW-1:0] ea;
      ea = AW'(12'h020 | ((12'h1E + k) & 12'h1F));
      chk("R5 R6 write address", {20'd0, va[k]}, {20'd0, ea});
      chk("R6 write data", {24'd0, vd[k]}, {24'd0, wd[k]});
    end
    chk("R7 commit on STOP", ncommit, 1);

    // R4: polling while busy.
    polls = 0; ack = 1'b0;
    while (!ack && polls < 30) begin
      bus_start();
      send_byte(dev(0), 0, ack);
      bus_stop();
      polls++;
      if (polls == 1) chk("R4 no ack while busy", {31'd0, ack}, 32'd0);
    end
    chk("R4 ack after busy", {31'd0, ack}, 32'd1);

    // R11/R10: selective and current-address reads.
    read_sel(12'h03E, 2, "R11 selective read");
    read_cur(12'h040, "R10 current read");
    read_sel(12'h020, 2, "R11 wrapped page data");

    // R12: wrap at the end of memory, then a long sequential run.
    read_sel(12'hFFF, 2, "R12 end wrap");
    read_cur(12'h001, "R10 pointer after wrap");
    chk("R12 line released after NoACK", {31'd0, sda_oe}, 32'd0);
    read_sel(12'h200, 40, "R12 sequential");

    // R8: START inside a data byte.
    vbase = nv; cbase = ncommit;
    bus_start();
    send_byte(dev(0), 0, ack);
    send_byte(8'h01, 0, ack);
    send_byte(8'h00, 0, ack);
    send_byte(8'h77, 0, ack);
    send_bits(8'h3C, 4, 0);
    bus_start();
    begin
      logic [7:0] b;
      send_byte(dev(1), 0, ack);
      recv_byte(1'b0, b);
      bus_stop();
      chk("R8 pointer after START abort", {23'd0, ack, b}, {23'd0, 1'b1, mem[12'h101]});
    end
    chk("R8 strobes on START abort", nv - vbase, 1);
    chk("R8 no commit on START abort", ncommit - cbase, 0);

    // R8: STOP inside a data byte.
    vbase = nv;
    bus_start();
    send_byte(dev(0), 0, ack);
    send_byte(8'h01, 0, ack);
    send_byte(8'h10, 0, ack);
    send_byte(8'h55, 0, ack);
    send_bits(8'hA5, 3, 0);
    bus_stop();
    chk("R8 no commit on cut STOP", ncommit - cbase, 0);
    chk("R8 strobes on cut STOP", nv - vbase, 1);
    read_cur(12'h111, "R8 pointer after cut STOP");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule